// File: doc/BRIEF.md
# Split-Transaction Memory Target Port

This block is the target side of a point-to-point, single-clock request/response port placed in front of a small word-addressed storage array. The initiator presents a command, a word address, write data and byte-lane enables. The block answers with a combinational accept. Responses travel on their own phase, separate from requests. Each response carries a two-bit completion code and a read-data bus that is separate from the write-data bus. The initiator may issue new requests while older responses are still owed. A four-entry pending-response queue lies between the two phases, so responses always leave in the order their requests were accepted.

Plain writes and broadcast writes are posted: they update storage and produce no response. Reads, non-posted writes and unsupported command codes each produce exactly one response. An address beyond the array, or an unknown command, gives an error completion and leaves storage untouched. When response back-pressure is enabled, the initiator holds off a response by keeping the response accept low. The block then keeps that response steady until it is taken.

Top module: `mem_target_port`

## Requirements
- R1: Out of reset, with no command presented, req_accept_o is 1, rsp_code_o is 0 (none) and rsp_rdata_o is 0.
- R2: Command codes are idle=0, write=1, read=2, non-posted write=5 and broadcast=7. Write and broadcast are posted: they are always accepted and never add a response. Read and non-posted write each add exactly one response.
- R3: A read, a non-posted write or an unsupported command is accepted only while fewer than 4 responses are pending. An unaccepted request is held unchanged by the initiator and is retried.
- R4: Responses appear in acceptance order. A response is first visible in the cycle after its request is accepted.
- R5: Response codes are none=0, valid=1, fail=2 and error=3. Fail is never produced because no conditional write exists.
- R6: Command codes 3, 4 and 6 are accepted, answered with error and change no storage.
- R7: A word address at or above the array depth (16) does not touch storage. Reads and non-posted writes to such an address are answered with error, and posted writes to it are dropped.
- R8: Bit i of req_be_i covers data bits 8i+7..8i. A write updates only the enabled bytes. A read returns the enabled bytes and zero in the disabled ones.
- R9: While rsp_accept_i is 0, a presented response code and its data stay unchanged. A response is removed only in a cycle with rsp_accept_i at 1.
- R10: A request may be accepted in the same cycle that a response is taken. Both take effect, and the queue count stays consistent.
- R11: Valid reads return data on rsp_rdata_o. Every other response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_cmd_i | input | 3 | Request command code |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | DATA_W/8 | Byte-lane enables |
| req_accept_o | output | 1 | Request accepted this cycle |
| rsp_code_o | output | 2 | Response completion code, 0 when none |
| rsp_rdata_o | output | DATA_W | Read data of the presented response |
| rsp_accept_i | input | 1 | Initiator takes the presented response |

## Verification
Two things can fall in the same clock edge: acceptance of a new request that enqueues a response, and departure of the queue head. The bench provokes this directly. It first holds rsp_accept_i low until the queue fills and a fifth read stalls. It then drains the queue while reads keep arriving. The random phase later toggles both sides at random. Each cycle the outputs are compared against a bench model of the storage and of the ordered response queue. Any lost or duplicated entry would show up as a wrong accept, a wrong code or wrong data at the head.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam logic [2:0] CMD_IDLE  = 3'd0;
  localparam logic [2:0] CMD_WR    = 3'd1;
  localparam logic [2:0] CMD_RD    = 3'd2;
  localparam logic [2:0] CMD_WRNP  = 3'd5;
  localparam logic [2:0] CMD_BCAST = 3'd7;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_OK   = 2'd1,
    RSP_FAIL = 2'd2,
    RSP_ERR  = 2'd3
  } rsp_code_e;
endpackage

// File: rtl/mtp_decode.sv
module mtp_decode
  import mtp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16
) (
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              posted_o,
  output logic              need_rsp_o,
  output logic              wr_o,
  output logic              rd_o,
  output rsp_code_e         code_o
);
  localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

  logic in_range;
  assign in_range = {1'b0, addr_i} < DEPTH_L;

  always_comb begin
    posted_o   = 1'b0;
    need_rsp_o = 1'b0;
    wr_o       = 1'b0;
    rd_o       = 1'b0;
    code_o     = RSP_NONE;
    case (cmd_i)
      CMD_IDLE: ;
      CMD_WR, CMD_BCAST: begin
        posted_o = 1'b1;
        wr_o     = in_range;
      end
      CMD_RD: begin
        need_rsp_o = 1'b1;
        rd_o       = in_range;
        code_o     = in_range ? RSP_OK : RSP_ERR;
      end
      CMD_WRNP: begin
        need_rsp_o = 1'b1;
        wr_o       = in_range;
        code_o     = in_range ? RSP_OK : RSP_ERR;
      end
      default: begin
        need_rsp_o = 1'b1;
        code_o     = RSP_ERR;
      end
    endcase
  end
endmodule

// File: rtl/mtp_store.sv
module mtp_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] lane_mask;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{be_i[b]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[idx_i] <= (mem[idx_i] & ~lane_mask) | (wdata_i & lane_mask);
    end
  end

  assign rdata_o = mem[idx_i] & lane_mask;
endmodule

// File: rtl/mtp_resp_fifo.sv
module mtp_resp_fifo #(
  parameter int WIDTH  = 34,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic do_push, do_pop;

  assign full_o  = count == CNT_W'(DEPTH);
  assign empty_o = count == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = slot[rd_ptr];
  assign count_o = count;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (do_push) begin
        slot[wr_ptr] <= din_i;
        wr_ptr       <= nxt(wr_ptr);
      end
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mem_target_port.sv
module mem_target_port
  import mtp_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int QDEPTH  = 4,
  parameter bit RESP_BP = 1'b1,
  localparam int BE_W   = DATA_W / 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(QDEPTH + 1),
  localparam int ENT_W  = 2 + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  output logic              req_accept_o,
  output logic [1:0]        rsp_code_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              rsp_accept_i
);
  logic posted, need_rsp, dec_wr, dec_rd;
  rsp_code_e dec_code;
  logic fire, q_push, q_pop, q_full, q_empty;
  logic [CNT_W-1:0]  q_count;
  logic [DATA_W-1:0] st_rdata;
  logic [ENT_W-1:0]  q_din, q_dout;

  mtp_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
    .cmd_i      (req_cmd_i),
    .addr_i     (req_addr_i),
    .posted_o   (posted),
    .need_rsp_o (need_rsp),
    .wr_o       (dec_wr),
    .rd_o       (dec_rd),
    .code_o     (dec_code)
  );

  // posted writes never need a queue slot
  assign req_accept_o = posted || !q_full;
  assign fire         = req_accept_o && (req_cmd_i != CMD_IDLE);
  assign q_push       = fire && need_rsp;

  mtp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fire && dec_wr),
    .idx_i   (req_addr_i[IDX_W-1:0]),
    .wdata_i (req_wdata_i),
    .be_i    (req_be_i),
    .rdata_o (st_rdata)
  );

  assign q_din = {dec_code, dec_rd ? st_rdata : '0};

  if (RESP_BP) begin : g_bp
    assign q_pop = !q_empty && rsp_accept_i;
  end else begin : g_nobp
    assign q_pop = !q_empty;
  end

  mtp_resp_fifo #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .din_i   (q_din),
    .pop_i   (q_pop),
    .dout_o  (q_dout),
    .full_o  (q_full),
    .empty_o (q_empty),
    .count_o (q_count)
  );

  assign rsp_code_o  = q_empty ? RSP_NONE : q_dout[ENT_W-1 -: 2];
  assign rsp_rdata_o = q_empty ? '0 : q_dout[DATA_W-1:0];
endmodule

// File: rtl/mtp_checker.sv
module mtp_checker #(
  parameter int DATA_W  = 32,
  parameter int QDEPTH  = 4,
  parameter bit RESP_BP = 1'b1,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        req_cmd_i,
  input logic              req_accept_o,
  input logic [1:0]        rsp_code_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_accept_i,
  input logic [CNT_W-1:0]  q_count,
  input logic              q_pop
);
  assert_stall_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == CNT_W'(QDEPTH) && req_cmd_i == 3'd2) |-> !req_accept_o);

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(QDEPTH));

  assert_posted_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_cmd_i == 3'd1 || req_cmd_i == 3'd7) |-> req_accept_o);

  assert_posted_no_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_cmd_i == 3'd1 && !q_pop) |=> q_count == $past(q_count));

  assert_code_when_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_code_o != 2'd0) == (q_count != '0));

  assert_no_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_code_o != 2'd2);

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RESP_BP && rsp_code_o != 2'd0 && !rsp_accept_i)
      |=> ($stable(rsp_code_o) && $stable(rsp_rdata_o)));
endmodule

bind mem_target_port mtp_checker #(
  .DATA_W  (DATA_W),
  .QDEPTH  (QDEPTH),
  .RESP_BP (RESP_BP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_cmd_i    (req_cmd_i),
  .req_accept_o (req_accept_o),
  .rsp_code_o   (rsp_code_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .rsp_accept_i (rsp_accept_i),
  .q_count      (q_count),
  .q_pop        (q_pop)
);

// File: tb/mem_target_port_test.sv
module mem_target_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  req_cmd_i = '0;
  logic [5:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [3:0]  req_be_i = '0;
  logic        req_accept_o;
  logic [1:0]  rsp_code_o;
  logic [31:0] rsp_rdata_o;
  logic        rsp_accept_i = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mm [DEPTH];
  logic [1:0]  qc [4];
  logic [31:0] qd [4];
  int qh = 0;
  int qn = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_target_port uut (
    .clk_i, .rst_ni, .req_cmd_i, .req_addr_i, .req_wdata_i, .req_be_i,
    .req_accept_o, .rsp_code_o, .rsp_rdata_o, .rsp_accept_i
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic bit is_posted(input logic [2:0] c);
    return c == 3'd1 || c == 3'd7;
  endfunction

  // one cycle: drive at negedge, check just after, update model for the edge
  task automatic step(input string tag, input logic [2:0] c, input logic [5:0] a,
                      input logic [31:0] d, input logic [3:0] b, input logic ra,
                      output logic acc);
    logic exp_acc, in_rng;
    logic [1:0] ecode;
    logic [31:0] edata;
    req_cmd_i = c; req_addr_i = a; req_wdata_i = d; req_be_i = b; rsp_accept_i = ra;
    #1;
    exp_acc = is_posted(c) || qn < 4;
    chk("R3 accept", {31'd0, req_accept_o}, {31'd0, exp_acc});
    chk({tag, " code"}, {30'd0, rsp_code_o}, qn > 0 ? {30'd0, qc[qh]} : 32'd0);
    chk({tag, " rdata"}, rsp_rdata_o, qn > 0 ? qd[qh] : 32'd0);
    in_rng = a < 6'(DEPTH);
    ecode = 2'd3; edata = '0;
    if (c == 3'd2 && in_rng) begin ecode = 2'd1; edata = mm[a[3:0]] & lane_mask(b); end
    if (c == 3'd5 && in_rng) ecode = 2'd1;
    if (qn > 0 && ra) begin qh = (qh + 1) % 4; qn--; end
    if (exp_acc && c != 3'd0) begin
      if (!is_posted(c)) begin
        qc[(qh + qn) % 4] = ecode;
        qd[(qh + qn) % 4] = edata;
        qn++;
      end
      if ((is_posted(c) || c == 3'd5) && in_rng)
        mm[a[3:0]] = (mm[a[3:0]] & ~lane_mask(b)) | (d & lane_mask(b));
    end
    acc = exp_acc;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drain(input string tag);
    logic acc;
    for (int i = 0; i < 10 && qn > 0; i++) step(tag, 3'd0, '0, '0, '0, 1'b1, acc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic acc;
    logic [2:0] c; logic [5:0] a; logic [31:0] d; logic [3:0] b;
    int r;
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    r = int'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 accept", {31'd0, req_accept_o}, 32'd1);
    chk("R1 code", {30'd0, rsp_code_o}, 32'd0);
    chk("R1 rdata", rsp_rdata_o, 32'd0);
    @(negedge clk_i);

    // posted write, then read back
    step("R2", 3'd1, 6'd3, 32'hA5A5_1234, 4'hF, 1'b1, acc);
    step("R2", 3'd0, 6'd0, '0, '0, 1'b1, acc);
    chk("R2 posted no rsp", {30'd0, rsp_code_o}, 32'd0);
    step("R11", 3'd2, 6'd3, '0, 4'hF, 1'b1, acc);
    chk("R11 read data", rsp_rdata_o, 32'hA5A5_1234);
    chk("R5 valid code", {30'd0, rsp_code_o}, 32'd1);
    step("R11", 3'd5, 6'd7, 32'h0BAD_F00D, 4'hF, 1'b1, acc);
    chk("R11 wrnp zero data", rsp_rdata_o, 32'd0);
    step("R2", 3'd7, 6'd8, 32'h1111_2222, 4'hF, 1'b1, acc);
    step("R2", 3'd2, 6'd8, '0, 4'hF, 1'b1, acc);
    chk("R2 broadcast stored", rsp_rdata_o, 32'h1111_2222);

    // byte enables
    step("R8", 3'd1, 6'd3, 32'hFFFF_FFFF, 4'b0101, 1'b1, acc);
    step("R8", 3'd2, 6'd3, '0, 4'b0011, 1'b1, acc);
    chk("R8 partial", rsp_rdata_o, 32'h0000_12FF);
    step("R8", 3'd2, 6'd3, '0, 4'hF, 1'b1, acc);
    chk("R8 merged", rsp_rdata_o, 32'hA5FF_12FF);

    // out of range
    step("R7", 3'd2, 6'd20, '0, 4'hF, 1'b1, acc);
    chk("R7 read error", {30'd0, rsp_code_o}, 32'd3);
    step("R7", 3'd5, 6'd19, 32'hDEAD_BEEF, 4'hF, 1'b1, acc);
    chk("R7 wrnp error", {30'd0, rsp_code_o}, 32'd3);
    step("R7", 3'd1, 6'd19, 32'hDEAD_BEEF, 4'hF, 1'b1, acc);
    step("R7", 3'd2, 6'd3, '0, 4'hF, 1'b1, acc);
    chk("R7 no alias write", rsp_rdata_o, 32'hA5FF_12FF);

    // unsupported commands
    step("R6", 3'd3, 6'd5, 32'h5555_5555, 4'hF, 1'b1, acc);
    chk("R6 cmd3 error", {30'd0, rsp_code_o}, 32'd3);
    step("R6", 3'd4, 6'd5, 32'h5555_5555, 4'hF, 1'b1, acc);
    step("R6", 3'd6, 6'd5, 32'h5555_5555, 4'hF, 1'b1, acc);
    step("R6", 3'd2, 6'd5, '0, 4'hF, 1'b1, acc);
    chk("R6 storage untouched", rsp_rdata_o, 32'd0);
    drain("R4");

    // fill the queue under back-pressure
    for (int i = 0; i < 4; i++) step("R9", 3'd2, 6'(i), '0, 4'hF, 1'b0, acc);
    step("R9", 3'd2, 6'd4, '0, 4'hF, 1'b0, acc);
    chk("R3 stall when full", {31'd0, req_accept_o}, 32'd0);
    step("R9", 3'd1, 6'd9, 32'h9999_0000, 4'hF, 1'b0, acc);
    chk("R3 posted while full", {31'd0, acc}, 32'd1);
    step("R9", 3'd5, 6'd9, '0, 4'hF, 1'b0, acc);
    // drain with new reads arriving each cycle
    for (int i = 0; i < 8; i++) step("R10", 3'd2, 6'd9, '0, 4'hF, 1'b1, acc);
    chk("R10 head after overlap", rsp_rdata_o, 32'h9999_0000);
    drain("R10");

    // random traffic with request hold
    c = 3'd0; a = '0; d = '0; b = '0; acc = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      if (acc) begin
        r = int'($urandom % 10);
        case (r)
          0:       c = 3'd0;
          1, 2:    c = 3'd1;
          3, 4, 5: c = 3'd2;
          6, 7:    c = 3'd5;
          8:       c = 3'd7;
          default: c = ($urandom % 2 == 0) ? 3'd3 : 3'd6;
        endcase
        a = 6'($urandom % 20);
        d = $urandom;
        b = 4'($urandom);
      end
      step("R4", c, a, d, b, ($urandom % 10) < 7, acc);
    end
    drain("R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule